// File: doc/BRIEF.md
# Shared Cache Per-Line Request Tracker

This block sits between the lookup path of a shared second-level cache and the memory side. Each line that has requests outstanding owns one tracker entry. The entry holds the line address, a count of outstanding non-atomic requests and a count of outstanding atomic requests. Several requests to the same line share one entry. The entry returns to the free pool on the cycle after both of its counts reach zero.

An atomic to a line waits at the input while any earlier non-atomic request to that line is still outstanding. Because it waits at the input, every request behind it also waits, so arrival order is kept. The entry stores no per-request requester identifier or bypass flags. Each downstream request carries them out together with its entry tag, and the memory side hands them back with the response. Two requests that share an entry therefore cannot overwrite each other's routing or classification. A response updates its entry's counts and is forwarded upstream one cycle later.

Top module: `l2_req_tracker`

## Requirements
- R1: After reset, `dn_valid` and `ret_valid` are low and `req_ready` is high.
- R2: A request accepted in a cycle (`req_valid` and `req_ready` both high) appears on the downstream outputs in the next cycle with the same line address, atomic flag, requester identifier and bypass flags. `dn_valid` is low in every cycle that does not follow an acceptance.
- R3: While a line has requests outstanding, every further request to that line is given the same `dn_tag`. No two live entries ever hold the same line address.
- R4: Requests to distinct lines that are outstanding together receive distinct tags. When all 8 entries are in use, a request to a line with no entry sees `req_ready` low.
- R5: An entry is freed on the cycle after its last outstanding response. A stalled request to a new line is then accepted into that entry, which is the lowest-numbered free one.
- R6: An atomic (`req_atomic` = 1) to a line with outstanding non-atomic requests sees `req_ready` low.
- R7: `req_ready` stays low for a held atomic in the cycle of the last non-atomic response to its line, and rises in the following cycle.
- R8: A response is presented on `ret_*` one cycle after `rsp_valid`. It carries the echoed requester identifier, bypass flags and atomic flag, and the line address held by the entry named by `rsp_tag`.
- R9: A non-atomic response (`rsp_atomic` = 0) never changes the entry's atomic count. The entry stays live while an atomic is outstanding, and another atomic to the line is accepted at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Upstream request present |
| req_ready | output | 1 | Request accepted this cycle when high |
| req_addr | input | AW | Line address of the request |
| req_atomic | input | 1 | 1 = atomic, 0 = load or store |
| req_src | input | SW | Requesting first-level cache identifier |
| req_byp | input | BW | Cache bypass flags |
| dn_valid | output | 1 | Downstream request valid (registered) |
| dn_tag | output | TW | Tracker entry index |
| dn_addr | output | AW | Line address |
| dn_atomic | output | 1 | Atomic flag |
| dn_src | output | SW | Requester identifier sent downstream |
| dn_byp | output | BW | Bypass flags sent downstream |
| rsp_valid | input | 1 | Memory response present |
| rsp_tag | input | TW | Entry index echoed by memory |
| rsp_atomic | input | 1 | Echoed atomic flag |
| rsp_src | input | SW | Echoed requester identifier |
| rsp_byp | input | BW | Echoed bypass flags |
| ret_valid | output | 1 | Upstream return valid (registered) |
| ret_addr | output | AW | Line address of the returning entry |
| ret_atomic | output | 1 | Atomic flag of the return |
| ret_src | output | SW | Requester to route the return to |
| ret_byp | output | BW | Bypass flags for classifying the return |

## Verification
The assertions check the following on every cycle:
- No two live entries share a line address.
- A free entry has both counts at zero.
- An atomic never gets `req_ready` while its line has non-atomics outstanding.
- A non-atomic response leaves the atomic count untouched.
- Downstream and return outputs follow acceptances and responses one cycle later, with the tags echoed.

Only the bench scenarios can show the following, because each depends on a specific history of requests and responses:
- The exact release cycle of a held atomic.
- Reuse of the lowest free entry after a full table stalls a new line.
- Survival of an entry kept alive only by an outstanding atomic.

// File: rtl/l2trk_pkg.sv
package l2trk_pkg;
  typedef enum logic {
    KIND_PLAIN  = 1'b0,
    KIND_ATOMIC = 1'b1
  } kind_e;
endpackage

// File: rtl/l2trk_find.sv
// Lowest-index search over a bit vector.
module l2trk_find #(
  parameter int N = 8,
  localparam int W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0] vec,
  output logic         any,
  output logic [W-1:0] idx
);
  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) begin
        any = 1'b1;
        idx = W'(i);
      end
    end
  end
endmodule

// File: rtl/l2trk_entry.sv
// One tracker entry: line address plus non-atomic and atomic outstanding counts.
module l2trk_entry #(
  parameter int AW = 26,
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          alloc,
  input  logic [AW-1:0] alloc_addr,
  input  logic          inc_na,
  input  logic          inc_at,
  input  logic          dec_na,
  input  logic          dec_at,
  output logic          vld,
  output logic [AW-1:0] addr,
  output logic [CW-1:0] na,
  output logic [CW-1:0] at
);
  logic [CW-1:0] na_n, at_n;

  always_comb begin
    na_n = na + CW'(inc_na) - CW'(dec_na);
    at_n = at + CW'(inc_at) - CW'(dec_at);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld  <= 1'b0;
      addr <= '0;
      na   <= '0;
      at   <= '0;
    end else begin
      if (alloc) addr <= alloc_addr;
      na  <= na_n;
      at  <= at_n;
      vld <= (na_n != '0) || (at_n != '0);
    end
  end
endmodule

// File: rtl/l2_req_tracker.sv
module l2_req_tracker #(
  parameter int NE   = 8,
  parameter int AW   = 26,
  parameter int SW   = 4,
  parameter int BW   = 2,
  parameter int MAXP = 15,
  localparam int TW  = (NE > 1) ? $clog2(NE) : 1,
  localparam int CW  = $clog2(MAXP + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_addr,
  input  logic          req_atomic,
  input  logic [SW-1:0] req_src,
  input  logic [BW-1:0] req_byp,
  output logic          dn_valid,
  output logic [TW-1:0] dn_tag,
  output logic [AW-1:0] dn_addr,
  output logic          dn_atomic,
  output logic [SW-1:0] dn_src,
  output logic [BW-1:0] dn_byp,
  input  logic          rsp_valid,
  input  logic [TW-1:0] rsp_tag,
  input  logic          rsp_atomic,
  input  logic [SW-1:0] rsp_src,
  input  logic [BW-1:0] rsp_byp,
  output logic          ret_valid,
  output logic [AW-1:0] ret_addr,
  output logic          ret_atomic,
  output logic [SW-1:0] ret_src,
  output logic [BW-1:0] ret_byp
);
  import l2trk_pkg::*;

  localparam logic [CW-1:0] CMAX = CW'(MAXP);

  logic [NE-1:0]         ent_vld;
  logic [NE-1:0][AW-1:0] ent_addr;
  logic [NE-1:0][CW-1:0] cnt_na;
  logic [NE-1:0][CW-1:0] cnt_at;
  logic [NE-1:0]         hit_vec;
  logic                  hit_any, free_any, can_take, accept;
  logic [TW-1:0]         hit_idx, free_idx, sel_idx;
  kind_e                 req_kind, rsp_kind;

  assign req_kind = kind_e'(req_atomic);
  assign rsp_kind = kind_e'(rsp_atomic);

  for (genvar i = 0; i < NE; i++) begin : g_hit
    assign hit_vec[i] = ent_vld[i] && (ent_addr[i] == req_addr);
  end

  l2trk_find #(.N(NE)) u_hit  (.vec(hit_vec),  .any(hit_any),  .idx(hit_idx));
  l2trk_find #(.N(NE)) u_free (.vec(~ent_vld), .any(free_any), .idx(free_idx));

  // Admission uses registered counts only, so a held atomic is released
  // in the cycle after its line's last non-atomic response.
  always_comb begin
    sel_idx = hit_any ? hit_idx : free_idx;
    if (hit_any) begin
      if (req_kind == KIND_ATOMIC)
        can_take = (cnt_na[hit_idx] == '0) && (cnt_at[hit_idx] != CMAX);
      else
        can_take = (cnt_na[hit_idx] != CMAX);
    end else begin
      can_take = free_any;
    end
  end

  assign req_ready = can_take;
  assign accept    = req_valid && can_take;

  for (genvar i = 0; i < NE; i++) begin : g_ent
    logic mine_req, mine_rsp;
    assign mine_req = accept && (sel_idx == TW'(i));
    assign mine_rsp = rsp_valid && (rsp_tag == TW'(i));
    l2trk_entry #(.AW(AW), .CW(CW)) u_ent (
      .clk        (clk),
      .rst        (rst),
      .alloc      (mine_req && !hit_any),
      .alloc_addr (req_addr),
      .inc_na     (mine_req && (req_kind == KIND_PLAIN)),
      .inc_at     (mine_req && (req_kind == KIND_ATOMIC)),
      .dec_na     (mine_rsp && (rsp_kind == KIND_PLAIN)),
      .dec_at     (mine_rsp && (rsp_kind == KIND_ATOMIC)),
      .vld        (ent_vld[i]),
      .addr       (ent_addr[i]),
      .na         (cnt_na[i]),
      .at         (cnt_at[i])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dn_valid   <= 1'b0;
      dn_tag     <= '0;
      dn_addr    <= '0;
      dn_atomic  <= 1'b0;
      dn_src     <= '0;
      dn_byp     <= '0;
      ret_valid  <= 1'b0;
      ret_addr   <= '0;
      ret_atomic <= 1'b0;
      ret_src    <= '0;
      ret_byp    <= '0;
    end else begin
      dn_valid   <= accept;
      dn_tag     <= sel_idx;
      dn_addr    <= req_addr;
      dn_atomic  <= req_atomic;
      dn_src     <= req_src;
      dn_byp     <= req_byp;
      ret_valid  <= rsp_valid;
      ret_addr   <= ent_addr[rsp_tag];
      ret_atomic <= rsp_atomic;
      ret_src    <= rsp_src;
      ret_byp    <= rsp_byp;
    end
  end
endmodule

// File: rtl/l2_req_tracker_chk.sv
module l2_req_tracker_chk #(
  parameter int NE = 8,
  parameter int AW = 26,
  parameter int SW = 4,
  parameter int BW = 2,
  parameter int TW = 3,
  parameter int CW = 4
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  req_valid,
  input logic                  req_ready,
  input logic                  req_atomic,
  input logic [AW-1:0]         req_addr,
  input logic                  dn_valid,
  input logic                  rsp_valid,
  input logic [TW-1:0]         rsp_tag,
  input logic                  rsp_atomic,
  input logic [SW-1:0]         rsp_src,
  input logic [BW-1:0]         rsp_byp,
  input logic                  ret_valid,
  input logic                  ret_atomic,
  input logic [SW-1:0]         ret_src,
  input logic [BW-1:0]         ret_byp,
  input logic [NE-1:0]         ent_vld,
  input logic [NE-1:0][AW-1:0] ent_addr,
  input logic [NE-1:0][CW-1:0] cnt_na,
  input logic [NE-1:0][CW-1:0] cnt_at
);
  p_issue_r2: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> dn_valid);
  p_no_spurious_r2: assert property (@(posedge clk) disable iff (rst)
    !(req_valid && req_ready) |=> !dn_valid);
  p_echo_r8: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> (ret_valid && ret_src == $past(rsp_src)
                   && ret_byp == $past(rsp_byp) && ret_atomic == $past(rsp_atomic)));

  for (genvar i = 0; i < NE; i++) begin : g_e
    p_hold_r6: assert property (@(posedge clk) disable iff (rst)
      (req_valid && req_atomic && ent_vld[i] && ent_addr[i] == req_addr
       && cnt_na[i] != '0) |-> !req_ready);
    p_idle_zero_r5: assert property (@(posedge clk) disable iff (rst)
      !ent_vld[i] |-> (cnt_na[i] == '0 && cnt_at[i] == '0));
    p_load_keeps_atomic_r9: assert property (@(posedge clk) disable iff (rst)
      (rsp_valid && !rsp_atomic && rsp_tag == TW'(i)
       && !(req_valid && req_ready && req_atomic)) |=> cnt_at[i] == $past(cnt_at[i]));
    for (genvar j = i + 1; j < NE; j++) begin : g_p
      p_unique_line_r3: assert property (@(posedge clk) disable iff (rst)
        !(ent_vld[i] && ent_vld[j] && ent_addr[i] == ent_addr[j]));
    end
  end
endmodule

bind l2_req_tracker l2_req_tracker_chk #(
  .NE(NE), .AW(AW), .SW(SW), .BW(BW), .TW(TW), .CW(CW)
) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
  .req_atomic(req_atomic), .req_addr(req_addr), .dn_valid(dn_valid),
  .rsp_valid(rsp_valid), .rsp_tag(rsp_tag), .rsp_atomic(rsp_atomic),
  .rsp_src(rsp_src), .rsp_byp(rsp_byp), .ret_valid(ret_valid),
  .ret_atomic(ret_atomic), .ret_src(ret_src), .ret_byp(ret_byp),
  .ent_vld(ent_vld), .ent_addr(ent_addr), .cnt_na(cnt_na), .cnt_at(cnt_at)
);

// File: tb/tb_l2_req_tracker.sv
`timescale 1ns/1ps
module tb_l2_req_tracker;
  localparam int NE = 8, AW = 26, SW = 4, BW = 2, TW = 3;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst = 1'b1;
  logic req_valid = 0, req_atomic = 0, req_ready;
  logic [AW-1:0] req_addr = '0;
  logic [SW-1:0] req_src = '0;
  logic [BW-1:0] req_byp = '0;
  logic dn_valid, dn_atomic;
  logic [TW-1:0] dn_tag;
  logic [AW-1:0] dn_addr;
  logic [SW-1:0] dn_src;
  logic [BW-1:0] dn_byp;
  logic rsp_valid = 0, rsp_atomic = 0;
  logic [TW-1:0] rsp_tag = '0;
  logic [SW-1:0] rsp_src = '0;
  logic [BW-1:0] rsp_byp = '0;
  logic ret_valid, ret_atomic;
  logic [AW-1:0] ret_addr;
  logic [SW-1:0] ret_src;
  logic [BW-1:0] ret_byp;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  l2_req_tracker dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_atomic(req_atomic), .req_src(req_src), .req_byp(req_byp),
    .dn_valid(dn_valid), .dn_tag(dn_tag), .dn_addr(dn_addr), .dn_atomic(dn_atomic),
    .dn_src(dn_src), .dn_byp(dn_byp), .rsp_valid(rsp_valid), .rsp_tag(rsp_tag),
    .rsp_atomic(rsp_atomic), .rsp_src(rsp_src), .rsp_byp(rsp_byp),
    .ret_valid(ret_valid), .ret_addr(ret_addr), .ret_atomic(ret_atomic),
    .ret_src(ret_src), .ret_byp(ret_byp)
  );

  task automatic chk(input bit ok, input string rq, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", rq, act, exp);
    end
  endtask

  task automatic issue(input logic [AW-1:0] a, input logic at, input logic [SW-1:0] s,
                       input logic [BW-1:0] b, input string rq, output logic [TW-1:0] tag);
    @(negedge clk);
    req_valid = 1; req_addr = a; req_atomic = at; req_src = s; req_byp = b;
    #1;
    while (!req_ready) begin @(negedge clk); #1; end
    @(negedge clk);
    req_valid = 0;
    chk(dn_valid == 1'b1, rq, dn_valid, 1);
    chk(dn_addr == a && dn_atomic == at && dn_src == s && dn_byp == b, rq,
        {dn_addr, dn_atomic, dn_src, dn_byp}, {a, at, s, b});
    tag = dn_tag;
  endtask

  task automatic reply(input logic [TW-1:0] t, input logic at, input logic [SW-1:0] s,
                       input logic [BW-1:0] b, input logic [AW-1:0] ea, input string rq);
    @(negedge clk);
    rsp_valid = 1; rsp_tag = t; rsp_atomic = at; rsp_src = s; rsp_byp = b;
    @(negedge clk);
    rsp_valid = 0;
    chk(ret_valid == 1'b1, rq, ret_valid, 1);
    chk(ret_src == s && ret_byp == b && ret_atomic == at, rq,
        {ret_src, ret_byp, ret_atomic}, {s, b, at});
    chk(ret_addr == ea, rq, ret_addr, ea);
  endtask

  task automatic t_reset();
    chk(dn_valid == 1'b0, "R1 dn_valid after reset", dn_valid, 0);
    chk(ret_valid == 1'b0, "R1 ret_valid after reset", ret_valid, 0);
    chk(req_ready == 1'b1, "R1 req_ready after reset", req_ready, 1);
  endtask

  task automatic t_share();
    logic [TW-1:0] t0, t1;
    logic [AW-1:0] a = 26'h0000A40;
    issue(a, 0, 4'd3, 2'd2, "R2 first load forwarded", t0);
    issue(a, 0, 4'd5, 2'd1, "R2 second request forwarded", t1);
    chk(t1 == t0, "R3 same line shares tag", t1, t0);
    reply(t1, 0, 4'd5, 2'd1, a, "R8 echo of second requester");
    reply(t0, 0, 4'd3, 2'd2, a, "R8 echo of first requester");
    @(negedge clk);
    chk(ret_valid == 1'b0, "R8 ret_valid single cycle", ret_valid, 0);
  endtask

  task automatic t_fill();
    logic [TW-1:0] tg [NE];
    logic [TW-1:0] tn;
    logic [AW-1:0] base = 26'h0100000;
    for (int i = 0; i < NE; i++)
      issue(base + AW'(i), 0, SW'(i), 2'd0, "R4 fill entries", tg[i]);
    for (int i = 0; i < NE; i++)
      for (int j = i + 1; j < NE; j++)
        chk(tg[i] != tg[j], "R4 distinct lines distinct tags", tg[i], tg[j]);
    @(negedge clk);
    req_valid = 1; req_addr = base + 26'd100; req_atomic = 0; req_src = 4'd9; req_byp = 2'd3;
    #1 chk(req_ready == 1'b0, "R4 full table stalls new line", req_ready, 0);
    @(negedge clk);
    #1 chk(req_ready == 1'b0, "R4 full table still stalled", req_ready, 0);
    reply(tg[3], 0, 4'd3, 2'd0, base + 26'd3, "R8 return during stall");
    #1 chk(req_ready == 1'b1, "R5 freed entry admits new line", req_ready, 1);
    @(negedge clk);
    req_valid = 0;
    chk(dn_valid == 1'b1 && dn_tag == tg[3], "R5 freed tag reused", {dn_valid, dn_tag}, {1'b1, tg[3]});
    tn = dn_tag;
    for (int i = 0; i < NE; i++)
      if (i != 3) reply(tg[i], 0, SW'(i), 2'd0, base + AW'(i), "R8 drain fill");
    reply(tn, 0, 4'd9, 2'd3, base + 26'd100, "R8 drain new line");
  endtask

  task automatic t_hold();
    logic [TW-1:0] tx;
    logic [AW-1:0] x = 26'h0200040;
    issue(x, 0, 4'd1, 2'd0, "R2 load before atomic", tx);
    @(negedge clk);
    req_valid = 1; req_addr = x; req_atomic = 1; req_src = 4'd7; req_byp = 2'd3;
    #1 chk(req_ready == 1'b0, "R6 atomic held behind load", req_ready, 0);
    @(negedge clk);
    #1 chk(req_ready == 1'b0, "R6 atomic still held", req_ready, 0);
    rsp_valid = 1; rsp_tag = tx; rsp_atomic = 0; rsp_src = 4'd1; rsp_byp = 2'd0;
    #0.5 chk(req_ready == 1'b0, "R7 not released in response cycle", req_ready, 0);
    @(negedge clk);
    rsp_valid = 0;
    #1 chk(req_ready == 1'b1, "R7 released next cycle", req_ready, 1);
    chk(ret_valid == 1'b1 && ret_atomic == 1'b0 && ret_src == 4'd1, "R8 load return",
        {ret_valid, ret_atomic, ret_src}, {1'b1, 1'b0, 4'd1});
    @(negedge clk);
    req_valid = 0;
    chk(dn_valid == 1'b1 && dn_atomic == 1'b1 && dn_tag == tx, "R7 atomic issued",
        {dn_valid, dn_atomic, dn_tag}, {1'b1, 1'b1, tx});
    reply(tx, 1, 4'd7, 2'd3, x, "R8 atomic return");
  endtask

  task automatic t_mix();
    logic [TW-1:0] ty, tl;
    logic [AW-1:0] y = 26'h0300080;
    issue(y, 1, 4'd2, 2'd1, "R9 first atomic", ty);
    issue(y, 0, 4'd4, 2'd0, "R9 load after atomic", tl);
    chk(tl == ty, "R3 load shares atomic entry", tl, ty);
    reply(tl, 0, 4'd4, 2'd0, y, "R9 load return routed");
    @(negedge clk);
    req_valid = 1; req_addr = y; req_atomic = 1; req_src = 4'd6; req_byp = 2'd2;
    #1 chk(req_ready == 1'b1, "R9 second atomic not held", req_ready, 1);
    @(negedge clk);
    req_valid = 0;
    chk(dn_valid == 1'b1 && dn_tag == ty, "R9 entry alive for atomic", {dn_valid, dn_tag}, {1'b1, ty});
    reply(ty, 1, 4'd2, 2'd1, y, "R8 first atomic return");
    reply(ty, 1, 4'd6, 2'd2, y, "R8 second atomic return");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_share();
    t_fill();
    t_hold();
    t_mix();
    repeat (2) @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(100000 * 5);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule